// File: doc/BRIEF.md
# Latched Interrupt Expander with Identification Window

This block collects up to sixteen external event lines into a latched status word, filters that word through a mask, and drives a single active-low level interrupt towards a host processor. The host reaches it over a simple synchronous 16-bit register bus with an 8-bit byte address, a read strobe, a write strobe and write data. Each event line passes through a two-flop synchronizer. A rising edge on the synchronized line sets its status bit, and the bit stays set until software clears it.

A status bit is cleared through a separate clear register. While a bit of that register is 1, the matching status bit is forced to 0 and new edges on that line are dropped. Writing 0 to the clear register releases the bit. The same register window holds three constant identification words, which let software confirm that the device is present. It also holds a code-version word, a board-ID word, an LED output register, a module-reset output register and a synchronized button input register. Register decoding uses an enumerated select (`SEL_LED`, `SEL_BTN`, `SEL_STAT`, `SEL_CLR`, `SEL_MASK`, `SEL_ID1`, `SEL_ID2`, `SEL_VER`, `SEL_ID3`, `SEL_MRST`, `SEL_BRD`, `SEL_NONE`). Any strobe selects exactly one of these values.

Top module: `irq_expander`

## Requirements
- R1: Reset (rst_n low) sets status, clear, LED and module-reset registers to 0 and the mask register to 0xFFFF, and drives irq_n_o high.
- R2: Reads of byte offset 0x40 return 0xAAAA, 0x48 return 0x5555, 0x58 return 0xCAFE, 0x50 return parameter CODE_VER and 0x68 return parameter BOARD_ID.
- R3: A read strobe loads bus_rdata on the following clock edge, and bus_rdata holds between reads. A read of any offset not listed in R2 or R11 returns 0x0000.
- R4: A status bit sets two clock edges after its source is first sampled high by the synchronizer, on a 0-to-1 transition only. A source held high does not set the bit again after it has been cleared. This applies to all bits, including reserved bits 5..15.
- R5: A set status bit stays set until the matching clear bit is 1.
- R6: While a clear-register bit is 1, the matching status bit reads 0 from the next edge onward and rising edges on that source are ignored. After 0 is written back, new edges set the bit again.
- R7: irq_n_o is low exactly when some status bit is 1 and its mask bit is 0. A mask bit of 1 blocks its source. irq_n_o follows a change of status or mask one clock edge later.
- R8: Writes to the status, button, identification, version and board-ID offsets change no state.
- R9: The LED register (0x00) and the module-reset register (0x60) read back what was written and drive led_o and mod_rst_o.
- R10: The button register (0x08) returns btn_i after a two-flop synchronizer.
- R11: Status is at offset 0x10, clear at 0x20 and mask at 0x38, all 16 bits, and the mask is read and writable. Status bit 0 is the Ethernet source, bit 1 is UART A, bit 2 is UART B, bit 3 is button A and bit 4 is button B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous event lines |
| btn_i | input | BTN_W | Asynchronous button levels |
| bus_addr | input | 8 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| led_o | output | 16 | LED register contents |
| mod_rst_o | output | 16 | Module-reset register contents |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
A wrong status bit shows on the next read of offset 0x10. It also shows, one edge after the bit changes, as irq_n_o in the wrong state whenever that bit is unmasked. A clear or mask register holding the wrong value shows in how irq_n_o responds to the next source edge, and in the read of its own offset. The bench compares every port against a behavioural model on every cycle, so any wrong internal state is reported within a cycle of reaching a port.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 16;

    localparam logic [ADDR_W-1:0] OFF_LED  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_BTN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_MASK = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_ID1  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_ID2  = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_VER  = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_ID3  = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_MRST = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_BRD  = 8'h68;

    localparam logic [DATA_W-1:0] ID_WORD1 = 16'hAAAA;
    localparam logic [DATA_W-1:0] ID_WORD2 = 16'h5555;
    localparam logic [DATA_W-1:0] ID_WORD3 = 16'hCAFE;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_LED, SEL_BTN, SEL_STAT, SEL_CLR, SEL_MASK,
        SEL_ID1, SEL_ID2, SEL_VER, SEL_ID3, SEL_MRST, SEL_BRD
    } regsel_e;

    function automatic regsel_e decode_off(input logic [ADDR_W-1:0] a);
        regsel_e s;
        unique case (a)
            OFF_LED:  s = SEL_LED;
            OFF_BTN:  s = SEL_BTN;
            OFF_STAT: s = SEL_STAT;
            OFF_CLR:  s = SEL_CLR;
            OFF_MASK: s = SEL_MASK;
            OFF_ID1:  s = SEL_ID1;
            OFF_ID2:  s = SEL_ID2;
            OFF_VER:  s = SEL_VER;
            OFF_ID3:  s = SEL_ID3;
            OFF_MRST: s = SEL_MRST;
            OFF_BRD:  s = SEL_BRD;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/irqx_status.sv
module irqx_status #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] lvl_prev_q;
    logic [NUM_SRC-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev_q <= '0;
        end else begin
            lvl_prev_q <= lvl_i;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic rise;
        assign rise = lvl_i[i] & ~lvl_prev_q[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (clr_i[i]) begin
                status_q[i] <= 1'b0;
            end else if (rise) begin
                status_q[i] <= 1'b1;
            end
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/irqx_regs.sv
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int unsigned   NUM_SRC  = 16,
    parameter int unsigned   BTN_W    = 2,
    parameter logic [15:0]   CODE_VER = 16'h0010,
    parameter logic [15:0]   BOARD_ID = 16'h0301
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [BTN_W-1:0]   btn_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [DATA_W-1:0]  led_o,
    output logic [DATA_W-1:0]  mrst_o,
    output logic [DATA_W-1:0]  clr_o,
    output logic [DATA_W-1:0]  mask_o
);
    regsel_e            sel;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  led_q, mrst_q, clr_q, mask_q, rdata_q;

    assign sel = decode_off(addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q  <= '0;
            mrst_q <= '0;
            clr_q  <= '0;
            mask_q <= '1;
        end else if (wr_i) begin
            unique case (sel)
                SEL_LED:  led_q  <= wdata_i;
                SEL_MRST: mrst_q <= wdata_i;
                SEL_CLR:  clr_q  <= wdata_i;
                SEL_MASK: mask_q <= wdata_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_LED:  rd_mux = led_q;
            SEL_BTN:  rd_mux = DATA_W'(btn_i);
            SEL_STAT: rd_mux = DATA_W'(status_i);
            SEL_CLR:  rd_mux = clr_q;
            SEL_MASK: rd_mux = mask_q;
            SEL_ID1:  rd_mux = ID_WORD1;
            SEL_ID2:  rd_mux = ID_WORD2;
            SEL_VER:  rd_mux = CODE_VER;
            SEL_ID3:  rd_mux = ID_WORD3;
            SEL_MRST: rd_mux = mrst_q;
            SEL_BRD:  rd_mux = BOARD_ID;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata_o = rdata_q;
    assign led_o   = led_q;
    assign mrst_o  = mrst_q;
    assign clr_o   = clr_q;
    assign mask_o  = mask_q;
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irqx_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned BTN_W    = 2,
    parameter logic [15:0] CODE_VER = 16'h0010,
    parameter logic [15:0] BOARD_ID = 16'h0301
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [BTN_W-1:0]   btn_i,
    input  logic [7:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic [15:0]        led_o,
    output logic [15:0]        mod_rst_o,
    output logic               irq_n_o
);
    logic [NUM_SRC-1:0] src_sync;
    logic [BTN_W-1:0]   btn_sync;
    logic [NUM_SRC-1:0] status_w;
    logic [15:0]        clr_w;
    logic [15:0]        mask_w;
    logic               irq_n_q;

    irqx_sync #(.W(NUM_SRC)) i_src_sync (
        .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(src_sync)
    );

    irqx_sync #(.W(BTN_W)) i_btn_sync (
        .clk(clk), .rst_n(rst_n), .d_i(btn_i), .q_o(btn_sync)
    );

    irqx_status #(.NUM_SRC(NUM_SRC)) i_status (
        .clk(clk), .rst_n(rst_n), .lvl_i(src_sync),
        .clr_i(clr_w[NUM_SRC-1:0]), .status_o(status_w)
    );

    irqx_regs #(
        .NUM_SRC(NUM_SRC), .BTN_W(BTN_W),
        .CODE_VER(CODE_VER), .BOARD_ID(BOARD_ID)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .rd_i(bus_rd),
        .wr_i(bus_wr), .wdata_i(bus_wdata), .status_i(status_w),
        .btn_i(btn_sync), .rdata_o(bus_rdata), .led_o(led_o),
        .mrst_o(mod_rst_o), .clr_o(clr_w), .mask_o(mask_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= ~|(status_w & ~mask_w[NUM_SRC-1:0]);
        end
    end

    assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk
    import irqx_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [15:0]        bus_rdata,
    input logic               irq_n_o,
    input logic [NUM_SRC-1:0] status,
    input logic [15:0]        clr,
    input logic [15:0]        mask
);
    logic [NUM_SRC-1:0] live;
    logic               rd_unmapped;
    logic               wr_mask;

    assign live        = status & ~mask[NUM_SRC-1:0];
    assign rd_unmapped = bus_rd && (decode_off(bus_addr) == SEL_NONE);
    assign wr_mask     = bus_wr && (decode_off(bus_addr) == SEL_MASK);

    // R7
    irq_follows_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n_o == !(|$past(live))));

    // R6
    clear_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr[NUM_SRC-1:0]) |=> ((status & $past(clr[NUM_SRC-1:0])) == '0));

    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr[NUM_SRC-1:0]) & ~status) == '0));

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (bus_rdata == 16'h0000));

    // R8
    mask_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask));
endmodule

bind irq_expander irqx_chk #(.NUM_SRC(NUM_SRC)) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq_n_o(irq_n_o),
    .status(status_w), .clr(clr_w), .mask(mask_w)
);

// File: tb/test_irq_expander.sv
module test_irq_expander;
    localparam int          CLK_PERIOD = 10;
    localparam int          NSRC = 16;
    localparam int          NBTN = 2;
    localparam logic [15:0] VER  = 16'h0010;
    localparam logic [15:0] BRD  = 16'h0301;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic [NBTN-1:0] btn_i = '0;
    logic [7:0]      bus_addr = '0;
    logic            bus_rd = 1'b0;
    logic            bus_wr = 1'b0;
    logic [15:0]     bus_wdata = '0;
    logic [15:0]     bus_rdata, led_o, mod_rst_o;
    logic            irq_n_o;

    int n_checks = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    irq_expander #(.NUM_SRC(NSRC), .BTN_W(NBTN), .CODE_VER(VER), .BOARD_ID(BRD)) i_irq_expander (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .btn_i(btn_i),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_o(led_o),
        .mod_rst_o(mod_rst_o), .irq_n_o(irq_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_status, m_clr, m_mask, m_led, m_mrst, m_rdata, m_irq_n;
    int q_src[$];
    int q_btn[$];

    function automatic int model_read(input int a);
        case (a)
            'h00: return m_led;
            'h08: return q_btn[q_btn.size()-2];
            'h10: return m_status;
            'h20: return m_clr;
            'h38: return m_mask;
            'h40: return 'hAAAA;
            'h48: return 'h5555;
            'h50: return int'(VER);
            'h58: return 'hCAFE;
            'h60: return m_mrst;
            'h68: return int'(BRD);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 0; m_clr = 0; m_mask = 'hFFFF; m_led = 0; m_mrst = 0;
            m_rdata = 0; m_irq_n = 1;
            q_src = '{0, 0, 0};
            q_btn = '{0, 0, 0};
        end else begin
            int n_status, n_clr, n_mask, n_led, n_mrst, n_rdata, n_irq, rise;
            rise     = q_src[q_src.size()-2] & ~q_src[q_src.size()-3];
            n_status = (m_status | rise) & ~m_clr & 'hFFFF;
            n_irq    = ((m_status & ~m_mask & 'hFFFF) != 0) ? 0 : 1;
            n_rdata  = bus_rd ? model_read(int'(bus_addr)) : m_rdata;
            n_clr = m_clr; n_mask = m_mask; n_led = m_led; n_mrst = m_mrst;
            if (bus_wr) begin
                case (int'(bus_addr))
                    'h00: n_led  = int'(bus_wdata);
                    'h20: n_clr  = int'(bus_wdata);
                    'h38: n_mask = int'(bus_wdata);
                    'h60: n_mrst = int'(bus_wdata);
                    default: ;
                endcase
            end
            m_status = n_status; m_clr = n_clr; m_mask = n_mask; m_led = n_led;
            m_mrst = n_mrst; m_rdata = n_rdata; m_irq_n = n_irq;
            q_src.push_back(int'(src_i));
            q_btn.push_back(int'(btn_i));
            if (q_src.size() > 4) void'(q_src.pop_front());
            if (q_btn.size() > 4) void'(q_btn.pop_front());
        end
        started = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, all requirements observed at ports
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk("R3 rdata vs model", int'(bus_rdata), m_rdata);
            chk("R7 irq_n vs model", int'(irq_n_o), m_irq_n);
            chk("R9 led vs model", int'(led_o), m_led);
            chk("R9 mod_rst vs model", int'(mod_rst_o), m_mrst);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic pulse(input int bitno);
        @(negedge clk);
        src_i[bitno] = 1'b1;
        @(negedge clk);
        src_i[bitno] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values
        chk("R1 irq_n after reset", int'(irq_n_o), 1);
        chk("R1 led after reset", int'(led_o), 0);
        chk("R1 mod_rst after reset", int'(mod_rst_o), 0);
        rd(8'h38, 'hFFFF, "R1 mask reset");
        rd(8'h10, 0, "R1 status reset");
        rd(8'h20, 0, "R1 clear reset");
        // R2 identification
        rd(8'h40, 'hAAAA, "R2 id1");
        rd(8'h48, 'h5555, "R2 id2");
        rd(8'h58, 'hCAFE, "R2 id3");
        rd(8'h50, int'(VER), "R2 version");
        rd(8'h68, int'(BRD), "R2 board id");
        // R3 unmapped and hold
        rd(8'h04, 0, "R3 unmapped 0x04");
        rd(8'h7E, 0, "R3 unmapped 0x7E");
        rd(8'h40, 'hAAAA, "R3 read");
        idle(3);
        chk("R3 rdata holds", int'(bus_rdata), 'hAAAA);
        // R11 mask register
        wr(8'h38, 16'h001F);
        rd(8'h38, 'h1F, "R11 mask readback");
        // R4 edge sets, R7 masked source
        pulse(0);
        idle(4);
        rd(8'h10, 'h1, "R4 status bit0 set");
        chk("R7 masked source keeps irq high", int'(irq_n_o), 1);
        wr(8'h38, 16'h001E);
        chk("R7 irq one edge after unmask", int'(irq_n_o), 1);
        idle(1);
        chk("R7 irq low after unmask", int'(irq_n_o), 0);
        // R4/R5 held level on button A
        @(negedge clk); src_i[3] = 1'b1;
        idle(6);
        rd(8'h10, 'h9, "R5 status sticky");
        // R6 clear bit0 and ignore events while held
        wr(8'h20, 16'h0001);
        idle(1);
        rd(8'h10, 'h8, "R6 bit0 cleared");
        chk("R7 only masked bit3 left", int'(irq_n_o), 1);
        pulse(0);
        idle(4);
        rd(8'h10, 'h8, "R6 event ignored while clear held");
        wr(8'h20, 16'h0000);
        pulse(0);
        idle(4);
        rd(8'h10, 'h9, "R6 bit0 sets after release");
        // R4 level held: no new set after clear
        wr(8'h20, 16'h0008);
        wr(8'h20, 16'h0000);
        idle(4);
        rd(8'h10, 'h1, "R4 held level does not re-set");
        // R8 read-only writes
        wr(8'h10, 16'hFFFF);
        rd(8'h10, 'h1, "R8 status write ignored");
        wr(8'h40, 16'h0000);
        rd(8'h40, 'hAAAA, "R8 id write ignored");
        wr(8'h68, 16'h1234);
        rd(8'h68, int'(BRD), "R8 board id write ignored");
        // R9 outputs
        wr(8'h00, 16'h5A5A);
        chk("R9 led_o", int'(led_o), 'h5A5A);
        rd(8'h00, 'h5A5A, "R9 led readback");
        wr(8'h60, 16'h0003);
        chk("R9 mod_rst_o", int'(mod_rst_o), 3);
        rd(8'h60, 3, "R9 mod_rst readback");
        // R10 buttons
        @(negedge clk); btn_i = 2'b10;
        idle(3);
        rd(8'h08, 2, "R10 buttons");
        // R4 reserved bit 15
        wr(8'h20, 16'h0001);
        wr(8'h20, 16'h0000);
        wr(8'h38, 16'h7FFF);
        pulse(15);
        idle(4);
        rd(8'h10, 'h8000, "R4 reserved bit15");
        chk("R7 irq from bit15", int'(irq_n_o), 0);
        wr(8'h38, 16'hFFFF);
        chk("R7 irq still low one edge after mask", int'(irq_n_o), 0);
        idle(1);
        chk("R7 irq high after mask", int'(irq_n_o), 1);
        idle(2);
        finish_up();
    end
endmodule